// File: doc/BRIEF.md
# Switch Address Lookup Table

This block holds the forwarding database of a small three-port Ethernet switch. Software maintains a table of address entries through a small word-addressed register port. It stages an entry in three data word registers and then copies it into, or out of, a table slot by writing a slot index to a table-control register. Each port also has a two-bit forwarding state, and one control register enables lookups and wipes the table.

On the lookup side, the switch presents a destination MAC address and the port the frame came in on. One cycle later the block returns a hit flag and an egress port mask. The lowest-numbered address entry whose MAC matches wins. A unicast entry yields a single port. A multicast entry yields a port mask. A miss floods to every forwarding port except the ingress port. Ports that are not forwarding never appear in a returned mask.

Top module: `mac_lookup_table`

## Requirements
- R1: After reset every register reads zero. Register 0 is control: bit 31 (lookup enable) reads back as written, and bit 30 always reads 0.
- R2: Data word registers sit at addresses 2, 3 and 4 and read back the last value written. On commit, word at address 4 supplies entry bits 31:0, address 3 supplies bits 63:32, and bits 4:0 of address 2 supply entry bits 68:64.
- R3: Writing address 1 with bit 31 clear latches the slot index (low 4 bits) and loads that slot into the data words: address 2 gets bits 68:64 zero-extended, address 3 gets 63:32, address 4 gets 31:0. Address 1 reads back the index.
- R4: Writing address 1 with bit 31 set latches the index and stores the data words into that slot.
- R5: Writing register 0 with bit 30 set empties every slot (all bits zero) in that cycle.
- R6: Each cycle in which lk_valid is high produces rsp_valid exactly one cycle later. Otherwise rsp_valid, rsp_hit and rsp_mask are low.
- R7: A slot matches when its type field (bits 61:60) is 1 or 3 and bits 47:0 equal the looked-up MAC. Types 0 and 2 never match. The lowest matching index is used, and rsp_hit reports whether one exists.
- R8: A matching slot with bit 40 set is multicast: rsp_mask is bits 68:66 ANDed with the forwarding ports.
- R9: A matching slot with bit 40 clear is unicast. If bit 65 (blocked) is set, the mask is empty. Otherwise the mask is the one-hot of the port number in bits 67:66 when that port exists and is forwarding, and empty otherwise.
- R10: On a miss, rsp_mask holds all forwarding ports except the ingress port (an ingress value of 3 excludes none).
- R11: With lookup disabled, a request is answered with rsp_hit and rsp_mask both 0.
- R12: Port p's state sits at address 5+p in bits 1:0. Only value 3 counts as forwarding; values 0, 1 and 2 remove the port from every mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_src | input | 2 | Ingress port of the frame |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | A matching address entry was found |
| rsp_mask | output | 3 | Egress port mask |

## Verification
A slot that was corrupted or committed to the wrong index would show up at the very next lookup of its MAC as a wrong hit flag or mask. It would also show up when the slot is loaded back through the data words, one cycle after the table-control write. A wrong forwarding state would show in the first response after the state register write, as a port appearing in or vanishing from flood and multicast masks. A reference model in the bench tracks the table, data words and port states. It compares every response and every register read each cycle, so a divergence is caught in the cycle it reaches the ports. The bench runs directed patterns for shadowed entries, skipped types, blocked and absent ports, and state changes, followed by a long stretch of mixed register traffic and lookups.

// File: rtl/mac_lookup_table.sv
module mac_lookup_table #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  parameter int ADDR_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 lk_valid,
  input  logic [47:0]          lk_mac,
  input  logic [1:0]           lk_src,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [NUM_PORTS-1:0] rsp_mask
);
  localparam int IDX_W   = $clog2(NUM_ENTRIES);
  localparam int ENTRY_W = 66 + NUM_PORTS;
  localparam int TOP_W   = ENTRY_W - 64;
  localparam int PS_BASE = 5;

  logic [ENTRY_W-1:0]   tbl [NUM_ENTRIES];
  logic [31:0]          dw  [3];
  logic [1:0]           pstate [NUM_PORTS];
  logic                 lk_en;
  logic [IDX_W-1:0]     idx_q;

  logic [NUM_PORTS-1:0] fwd, src_oh;
  logic [NUM_ENTRIES-1:0] is_addr, match;
  logic [ENTRY_W-1:0]   sel;
  logic                 hit_any;
  logic [NUM_PORTS-1:0] mask_c;

  wire wr_ctrl = reg_wr && reg_addr == ADDR_W'(0);
  wire wr_tc   = reg_wr && reg_addr == ADDR_W'(1);
  wire [IDX_W-1:0] wr_idx = reg_wdata[IDX_W-1:0];
  wire idx_ok  = 32'(wr_idx) < NUM_ENTRIES;

  genvar gp, ge;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      assign fwd[gp]    = pstate[gp] == 2'd3;
      assign src_oh[gp] = lk_src == 2'(gp);
    end
    for (ge = 0; ge < NUM_ENTRIES; ge++) begin : g_ent
      assign is_addr[ge] = tbl[ge][60];
      assign match[ge]   = is_addr[ge] && tbl[ge][47:0] == lk_mac;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_ctrl && reg_wdata[30]) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_tc && reg_wdata[31] && idx_ok) begin
      tbl[wr_idx] <= {dw[0][TOP_W-1:0], dw[1], dw[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) dw[k] <= '0;
      for (int p = 0; p < NUM_PORTS; p++) pstate[p] <= '0;
      lk_en <= 1'b0;
      idx_q <= '0;
    end else if (reg_wr) begin
      if (wr_ctrl) lk_en <= reg_wdata[31];
      if (wr_tc) begin
        idx_q <= wr_idx;
        if (!reg_wdata[31] && idx_ok) begin
          dw[0] <= 32'(tbl[wr_idx][ENTRY_W-1:64]);
          dw[1] <= tbl[wr_idx][63:32];
          dw[2] <= tbl[wr_idx][31:0];
        end
      end
      for (int k = 0; k < 3; k++)
        if (reg_addr == ADDR_W'(2 + k)) dw[k] <= reg_wdata;
      for (int p = 0; p < NUM_PORTS; p++)
        if (reg_addr == ADDR_W'(PS_BASE + p)) pstate[p] <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(0)) reg_rdata = {lk_en, 31'b0};
    if (reg_addr == ADDR_W'(1)) reg_rdata = 32'(idx_q);
    for (int k = 0; k < 3; k++)
      if (reg_addr == ADDR_W'(2 + k)) reg_rdata = dw[k];
    for (int p = 0; p < NUM_PORTS; p++)
      if (reg_addr == ADDR_W'(PS_BASE + p)) reg_rdata = {30'b0, pstate[p]};
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = tbl[i];
  end
  assign hit_any = |match;

  always_comb begin
    mask_c = '0;
    if (!hit_any)
      mask_c = fwd & ~src_oh;
    else if (sel[40])
      mask_c = sel[ENTRY_W-1:66] & fwd;
    else if (!sel[65] && 32'(sel[67:66]) < NUM_PORTS)
      mask_c = fwd & (NUM_PORTS'(1) << sel[67:66]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_mask  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_en && hit_any;
      rsp_mask  <= (lk_valid && lk_en) ? mask_c : '0;
    end
  end

  p_rsp_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_rsp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_mask == '0));
  p_hit_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_en) |=> (!rsp_hit && rsp_mask == '0));
  p_fwd_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_mask & ~$past(fwd)) == '0);
  p_flood_excl_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_en && !hit_any) |=> (rsp_mask & $past(src_oh)) == '0);
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[30]) |=> is_addr == '0);
endmodule

// File: tb/tb_mac_lookup_table.sv
`timescale 1ns/1ps
module tb_mac_lookup_table;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        lk_valid = 0;
  logic [47:0] lk_mac = 0;
  logic [1:0]  lk_src = 0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_mask;

  always #2 clk = ~clk;

  mac_lookup_table dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .lk_valid, .lk_mac, .lk_src, .rsp_valid, .rsp_hit, .rsp_mask);

  logic [68:0] mtab [16];
  logic [31:0] mdw [3];
  logic [1:0]  mps [3];
  logic        men = 0;
  logic [3:0]  midx = 0;
  logic        exp_v = 0, exp_h = 0;
  logic [2:0]  exp_m = 0;
  string       exp_tag = "R6", note = "";
  int          vectors = 0, fails = 0;
  bit          done = 0;

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B = 48'h04_AA_BB_CC_DD_EE;
  localparam logic [47:0] MAC_C = 48'h01_00_5E_00_00_07;
  localparam logic [47:0] MAC_D = 48'h06_01_02_03_04_05;
  localparam logic [47:0] MAC_E = 48'h08_09_0A_0B_0C_0D;

  initial begin
    for (int i = 0; i < 16; i++) mtab[i] = '0;
    for (int k = 0; k < 3; k++) begin mdw[k] = 0; mps[k] = 0; end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return {men, 31'b0};
      4'd1: return {28'b0, midx};
      4'd2, 4'd3, 4'd4: return mdw[a - 2];
      4'd5, 4'd6, 4'd7: return {30'b0, mps[a - 5]};
      default: return 0;
    endcase
  endfunction

  function automatic string rtag(input logic [3:0] a);
    if (note != "") return note;
    if (a == 0) return "R1";
    if (a == 1) return "R3";
    if (a <= 4) return "R2";
    if (a <= 7) return "R12";
    return "R1";
  endfunction

  task automatic predict(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                         input logic lv, input logic [47:0] mac, input logic [1:0] src);
    logic [2:0] fwd;
    int found;
    for (int p = 0; p < 3; p++) fwd[p] = (mps[p] == 2'd3);
    exp_v = lv; exp_h = 0; exp_m = 0; exp_tag = "R6";
    if (lv) begin
      if (!men) exp_tag = "R11";
      else begin
        found = -1;
        for (int i = 0; i < 16; i++)
          if (found < 0 && (mtab[i][61:60] == 2'd1 || mtab[i][61:60] == 2'd3) && mtab[i][47:0] == mac)
            found = i;
        if (found < 0) begin
          exp_tag = "R10";
          exp_m = fwd;
          if (src < 3) exp_m[src] = 1'b0;
        end else begin
          exp_h = 1;
          if (mtab[found][40]) begin
            exp_tag = "R8";
            exp_m = mtab[found][68:66] & fwd;
          end else begin
            exp_tag = "R9";
            if (!mtab[found][65] && mtab[found][67:66] < 3 && fwd[mtab[found][67:66]])
              exp_m[mtab[found][67:66]] = 1'b1;
          end
        end
      end
    end
    if (note != "") exp_tag = note;
    if (wr) begin
      case (a)
        4'd0: begin
          men = wd[31];
          if (wd[30]) for (int i = 0; i < 16; i++) mtab[i] = '0;
        end
        4'd1: begin
          midx = wd[3:0];
          if (wd[31]) mtab[midx] = {mdw[0][4:0], mdw[1], mdw[2]};
          else begin
            mdw[0] = {27'b0, mtab[midx][68:64]};
            mdw[1] = mtab[midx][63:32];
            mdw[2] = mtab[midx][31:0];
          end
        end
        4'd2, 4'd3, 4'd4: mdw[a - 2] = wd;
        4'd5, 4'd6, 4'd7: mps[a - 5] = wd[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                      input logic lv, input logic [47:0] mac, input logic [1:0] src);
    @(negedge clk);
    cmp("R6", "rsp_valid", 32'(rsp_valid), 32'(exp_v));
    cmp("R7", "rsp_hit", 32'(rsp_hit), 32'(exp_h));
    cmp(exp_tag, "rsp_mask", 32'(rsp_mask), 32'(exp_m));
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    lk_valid = lv; lk_mac = mac; lk_src = src;
    #1;
    cmp(rtag(a), "reg_rdata", reg_rdata, mread(a));
    if (rst_n) predict(wr, a, wd, lv, mac, src);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] wd);
    step(1, a, wd, 0, '0, 0);
  endtask
  task automatic rreg(input logic [3:0] a);
    step(0, a, 0, 0, '0, 0);
  endtask
  task automatic look(input logic [47:0] mac, input logic [1:0] src);
    step(0, 4'd0, 0, 1, mac, src);
  endtask

  task automatic put(input int idx, input logic [68:0] e);
    wreg(4'd2, {27'b0, e[68:64]});
    wreg(4'd3, e[63:32]);
    wreg(4'd4, e[31:0]);
    note = "R4";
    wreg(4'd1, 32'h8000_0000 | 32'(idx));
    note = "";
  endtask

  function automatic logic [68:0] uc(input logic [1:0] typ, input logic [47:0] mac,
                                    input logic [1:0] port, input logic blk);
    logic [68:0] e = '0;
    e[61:60] = typ; e[47:0] = mac; e[67:66] = port; e[65] = blk;
    return e;
  endfunction
  function automatic logic [68:0] mc(input logic [47:0] mac, input logic [2:0] m);
    logic [68:0] e = '0;
    e[61:60] = 2'd1; e[63:62] = 2'd3; e[47:0] = mac; e[68:66] = m;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] pool [4];
    pool[0] = MAC_A; pool[1] = MAC_B; pool[2] = MAC_C; pool[3] = MAC_E;
    repeat (3) rreg(4'd0);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rreg(4'(a));              // R1 reset state
    note = "R1"; wreg(4'd0, 32'hC000_0000); rreg(4'd0); note = "";
    for (int p = 0; p < 3; p++) wreg(4'(5 + p), 32'h3);
    put(0, uc(2'd0, MAC_A, 2'd0, 0));   // R7 free type skipped
    put(1, uc(2'd2, MAC_A, 2'd1, 0));   // R7 VLAN type skipped
    put(2, uc(2'd1, MAC_A, 2'd2, 0));
    put(3, uc(2'd3, MAC_A, 2'd0, 0));   // shadowed by slot 2
    put(4, uc(2'd1, MAC_B, 2'd1, 1));   // R9 blocked
    put(5, mc(MAC_C, 3'b101));
    put(6, uc(2'd3, MAC_D, 2'd3, 0));   // R9 absent port
    look(MAC_A, 0); look(MAC_B, 0); look(MAC_C, 1); look(MAC_D, 0);
    look(MAC_E, 1); look(MAC_E, 3); look(MAC_E, 0);
    for (int s = 0; s < 3; s++) begin   // R12 non-forwarding states on port 2
      wreg(4'd7, 32'(s));
      look(MAC_A, 0); look(MAC_C, 1); look(MAC_E, 0);
    end
    wreg(4'd7, 32'h3);
    note = "R3"; wreg(4'd1, 32'h0000_0015); rreg(4'd2); rreg(4'd3); rreg(4'd4); rreg(4'd1);
    wreg(4'd1, 32'h0000_0002); rreg(4'd2); rreg(4'd3); rreg(4'd4); note = "";
    note = "R4"; put(8, mc(MAC_E, 3'b011)); note = "R4"; look(MAC_E, 2);
    wreg(4'd1, 32'd8); rreg(4'd2); rreg(4'd3); rreg(4'd4); note = "";
    note = "R11"; wreg(4'd0, 32'h0); look(MAC_A, 0); look(MAC_E, 1); note = "";
    note = "R5"; wreg(4'd0, 32'hC000_0000); rreg(4'd0);
    look(MAC_A, 1); look(MAC_C, 0);
    wreg(4'd1, 32'd5); rreg(4'd2); rreg(4'd3); rreg(4'd4); note = "";
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a;
      logic [31:0] wd;
      logic [47:0] m;
      int op;
      op = $urandom % 8;
      m = pool[$urandom % 4];
      wd = $urandom;
      case (op)
        0: begin a = 4'd3; wd = {2'b0, 2'($urandom), 12'($urandom), m[47:32]}; end
        1: begin a = 4'd4; wd = m[31:0]; end
        2: a = 4'd2;
        3: begin a = 4'd1; wd = {wd[31], 27'b0, wd[3:0]}; end
        4: begin a = 4'(5 + $urandom % 3); wd = ($urandom % 3 == 0) ? wd : 32'h3; end
        5: begin a = 4'd0; wd = {($urandom % 8 != 0), ($urandom % 32 == 0), 30'b0}; end
        default: a = 4'($urandom % 9);
      endcase
      step(($urandom % 3) != 0, a, wd, ($urandom % 2) == 1, m, 2'($urandom));
    end
    rreg(4'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule